// File: doc/BRIEF.md
# Pipelined Burst SRAM Datapath

This block is a synchronous, pipelined static RAM core. The word is 72 bits wide and split into eight 9-bit byte lanes. The depth is a parameter. Address, control and write data are captured on the rising clock edge. A read returns its word after one more edge: one register stage sits on the address side and one on the data side. Writes are committed on the edge that follows capture, so the caller sees no write latency. An external burst address generator supplies the address each cycle, together with a cycle-type input that marks the cycle as an access or a deselect. The block tells that generator, through an advance strobe, when an access has been accepted.

The data-lane drivers are controlled by a pipeline whose behaviour depends on a mode input. In single-cycle deselect mode, a captured deselect or write turns the drivers off straight away. In dual-cycle deselect mode, a deselect is held for one full cycle before the drivers are released. An asynchronous, active-low output enable can only mask drivers that the pipeline has marked active. A sleep input stops the block two cycles after it rises and keeps the array contents. When sleep is released, a short recovery window follows in which reads are accepted and writes are refused.

Top module: `pipe_burst_ram`

## Requirements
- R1: An access captured at edge k with no write enable active is a read. After edge k+1, `rdata` holds the word stored at the captured address.
- R2: With `dcd_mode` low, `dq_oe` is high after edge k+1 only if edge k captured a read and edge k+1 also captured a read. A captured deselect drops `dq_oe` right after the edge that captured it.
- R3: With `dcd_mode` high, a deselect captured at edge k+1, directly after a read captured at edge k, keeps `dq_oe` high after edge k+1 so that read's word is driven. A second deselect at edge k+2 drops it.
- R4: Lane i is bits [9i+8:9i]. With `bw_n` low, each lane whose `ben_n[i]` is low is written and the other lanes keep their contents. With `bw_n` low and all `ben_n` bits high, the cycle is a read.
- R5: With `gw_n` low, an access writes all eight lanes, whatever `bw_n` and `ben_n` are.
- R6: After any edge that captured a write, `dq_oe` is low, in either deselect mode.
- R7: `oe_n` high forces `dq_oe` low within the same cycle, with no clock edge. `oe_n` low re-enables only what the pipeline has marked active.
- R8: `adv` is high, combinationally, in every cycle whose access will be accepted. This includes a read taken while `oe_n` is high.
- R9: Suppose `sleep` is sampled high at edge a. An access at edge a+1 is still accepted. From edge a+2 on, every input except `sleep` is ignored (`adv` low) and `dq_oe` stays low. The array contents are kept.
- R10: Suppose `sleep` is sampled low again at edge b. At the REC_CYC edges starting with edge b+2, writes are refused (`adv` low, memory unchanged) and reads are accepted.
- R11: Reset is synchronous and active low. It leaves `dq_oe` low and `rdata` zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cyc_act | input | 1 | Cycle type: 1 access, 0 deselect |
| addr | input | $clog2(DEPTH) | Word address from the burst generator |
| wdata | input | LANES*LANE_W | Write data |
| gw_n | input | 1 | Global write, active low |
| bw_n | input | 1 | Byte-write enable, active low |
| ben_n | input | LANES | Per-lane write enables, active low |
| dcd_mode | input | 1 | 1 dual-cycle deselect, 0 single-cycle deselect |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Sleep request, active high |
| adv | output | 1 | Access accepted; advance the burst address |
| rdata | output | LANES*LANE_W | Read data |
| dq_oe | output | 1 | Data-lane driver enable for all lanes |

## Verification
Sleep entry and a read's data slot can land on the same edge. The bench issues back-to-back reads while raising `sleep`. It expects the first read's word to be driven after the edge that samples `sleep`, and the drivers to go quiet after the next edge, even though a read is still queued. It then wakes the block and reads back the words that a write issued during sleep and writes issued during recovery aimed at, to judge that neither reached the array.

// File: rtl/pbr_pkg.sv
// Shared command encoding for the pipelined burst RAM.
// Assumes one command per clock, decoded before the input registers.
package pbr_pkg;
    typedef enum logic [1:0] {
        CMD_IDLE = 2'd0,
        CMD_RD   = 2'd1,
        CMD_WR   = 2'd2
    } cmd_e;
endpackage

// File: rtl/pbr_ctrl.sv
// Command decoder with sleep and wake-up recovery handling.
// Assumes sleep is synchronous to clk; REC_CYC must be at least 1.
module pbr_ctrl
    import pbr_pkg::*;
#(
    parameter int LANES   = 8,
    parameter int REC_CYC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cyc_act,
    input  logic             gw_n,
    input  logic             bw_n,
    input  logic [LANES-1:0] ben_n,
    input  logic             sleep,
    output cmd_e             cmd,
    output logic [LANES-1:0] wmask,
    output logic             asleep,
    output logic             rec_busy
);
    localparam int RCW = $clog2(REC_CYC + 1);

    logic           slp1_q, slp2_q;
    logic [RCW-1:0] rec_q;
    logic           wr_req;

    // Two-stage sleep pipeline: the block sleeps two edges after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slp1_q <= 1'b0;
            slp2_q <= 1'b0;
        end else begin
            slp1_q <= sleep;
            slp2_q <= slp1_q;
        end
    end

    // Recovery counter: held full while asleep, counts down after waking.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rec_q <= '0;
        else if (slp2_q)
            rec_q <= RCW'(REC_CYC);
        else if (rec_q != '0)
            rec_q <= rec_q - 1'b1;
    end

    assign asleep   = slp2_q;
    assign rec_busy = (rec_q != '0);
    assign wr_req   = !gw_n || (!bw_n && (ben_n != '1));

    // Classify this cycle's command; sleep and recovery mask what is allowed.
    always_comb begin
        if (!cyc_act || slp2_q)
            cmd = CMD_IDLE;
        else if (wr_req)
            cmd = rec_busy ? CMD_IDLE : CMD_WR;
        else
            cmd = CMD_RD;
    end

    // Lane write mask: global write takes every lane.
    assign wmask = !gw_n ? '1 : (!bw_n ? ~ben_n : '0);
endmodule

// File: rtl/pbr_core.sv
// Input registers plus lane-sliced storage array with registered read data.
// Assumes the command arrives already decoded; memory is not reset.
module pbr_core
    import pbr_pkg::*;
#(
    parameter  int LANES  = 8,
    parameter  int LANE_W = 9,
    parameter  int DEPTH  = 256,
    localparam int AW     = $clog2(DEPTH),
    localparam int WW     = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cmd_e             cmd,
    input  logic [AW-1:0]    addr,
    input  logic [WW-1:0]    wdata,
    input  logic [LANES-1:0] wmask,
    output logic [WW-1:0]    rdata,
    output logic             wr_pend
);
    cmd_e             cmd_q;
    logic [AW-1:0]    addr_q;
    logic [WW-1:0]    wdata_q;
    logic [LANES-1:0] wmask_q;

    // Address-side stage: capture command, address, data and mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q   <= CMD_IDLE;
            addr_q  <= '0;
            wdata_q <= '0;
            wmask_q <= '0;
        end else begin
            cmd_q   <= cmd;
            addr_q  <= addr;
            wdata_q <= wdata;
            wmask_q <= wmask;
        end
    end

    assign wr_pend = (cmd_q == CMD_WR);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];
        logic [LANE_W-1:0] rd_q;

        // Self-timed write of this lane from the captured stage.
        always_ff @(posedge clk) begin
            if (wr_pend && wmask_q[g])
                mem[addr_q] <= wdata_q[g*LANE_W +: LANE_W];
        end

        // Data-side stage: read this lane for a captured read.
        always_ff @(posedge clk) begin
            if (!rst_n)
                rd_q <= '0;
            else if (cmd_q == CMD_RD)
                rd_q <= mem[addr_q];
        end

        assign rdata[g*LANE_W +: LANE_W] = rd_q;
    end
endmodule

// File: rtl/pbr_drive.sv
// Driver-enable pipeline for single- or dual-cycle deselect.
// Assumes oe_n is asynchronous; it only masks the pipelined enable.
module pbr_drive
    import pbr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  cmd_e cmd,
    input  logic dcd_mode,
    input  logic oe_n,
    input  logic asleep,
    output logic dq_oe
);
    cmd_e cmd1_q;
    logic rd2_q;
    logic hold;

    // Track the captured command and whether read data is now on the output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd1_q <= CMD_IDLE;
            rd2_q  <= 1'b0;
        end else begin
            cmd1_q <= cmd;
            rd2_q  <= (cmd1_q == CMD_RD);
        end
    end

    // A following read keeps drivers on; a deselect only in dual-cycle mode.
    assign hold  = (cmd1_q == CMD_RD) || (dcd_mode && cmd1_q == CMD_IDLE);
    assign dq_oe = rd2_q && hold && !asleep && !oe_n;
endmodule

// File: rtl/pipe_burst_ram.sv
// Top of the pipelined burst RAM: decoder, array pipeline and driver control.
// Assumes the burst address generator sits outside and follows adv.
module pipe_burst_ram
    import pbr_pkg::*;
#(
    parameter  int LANES   = 8,
    parameter  int LANE_W  = 9,
    parameter  int DEPTH   = 256,
    parameter  int REC_CYC = 4,
    localparam int AW      = $clog2(DEPTH),
    localparam int WW      = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cyc_act,
    input  logic [AW-1:0]    addr,
    input  logic [WW-1:0]    wdata,
    input  logic             gw_n,
    input  logic             bw_n,
    input  logic [LANES-1:0] ben_n,
    input  logic             dcd_mode,
    input  logic             oe_n,
    input  logic             sleep,
    output logic             adv,
    output logic [WW-1:0]    rdata,
    output logic             dq_oe
);
    cmd_e             cmd_w;
    logic [LANES-1:0] wmask_w;
    logic             asleep_w;
    logic             rec_busy_w;
    logic             wr_pend_w;

    pbr_ctrl #(.LANES(LANES), .REC_CYC(REC_CYC)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cyc_act(cyc_act), .gw_n(gw_n), .bw_n(bw_n),
        .ben_n(ben_n), .sleep(sleep), .cmd(cmd_w), .wmask(wmask_w),
        .asleep(asleep_w), .rec_busy(rec_busy_w)
    );

    pbr_core #(.LANES(LANES), .LANE_W(LANE_W), .DEPTH(DEPTH)) u_core (
        .clk(clk), .rst_n(rst_n), .cmd(cmd_w), .addr(addr), .wdata(wdata),
        .wmask(wmask_w), .rdata(rdata), .wr_pend(wr_pend_w)
    );

    pbr_drive u_drive (
        .clk(clk), .rst_n(rst_n), .cmd(cmd_w), .dcd_mode(dcd_mode),
        .oe_n(oe_n), .asleep(asleep_w), .dq_oe(dq_oe)
    );

    // Advance strobe for the burst generator: any accepted access.
    assign adv = (cmd_w != CMD_IDLE);

    // R7: output enable high always silences the lanes.
    a_r7_oe_masks: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !dq_oe);

    // R2: in single-cycle mode a deselect releases the lanes after its edge.
    a_r2_scd_release: assert property (@(posedge clk) disable iff (!rst_n)
        (!dcd_mode && !cyc_act) ##1 !dcd_mode |-> !dq_oe);

    // R6: a captured write never coincides with driven lanes.
    a_r6_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pend_w |-> !dq_oe);

    // R9: while asleep the lanes are released.
    a_r9_sleep_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        asleep_w |-> !dq_oe);

    // R10: no write is captured while asleep or recovering.
    a_r10_no_wake_write: assert property (@(posedge clk) disable iff (!rst_n)
        (asleep_w || rec_busy_w) |=> !wr_pend_w);

    // R8: an awake read request is always accepted, output enable aside.
    a_r8_read_advances: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_act && gw_n && (bw_n || (&ben_n)) && !asleep_w) |-> adv);
endmodule

// File: tb/sim_pipe_burst_ram.sv
module sim_pipe_burst_ram;
    localparam int PERIOD = 10;
    localparam logic [1:0] K_I = 2'd0, K_R = 2'd1, K_W = 2'd2, K_B = 2'd3;

    typedef struct packed {
        logic [1:0] kind;
        logic [7:0] a;
        logic [7:0] ben;
        logic       dcd;
        logic       oen;
        logic       exp_oe;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{K_W, 8'd5, 8'hFF, 1'b0, 1'b0, 1'b0},
        '{K_B, 8'd5, 8'hF5, 1'b0, 1'b0, 1'b0},
        '{K_R, 8'd5, 8'hFF, 1'b0, 1'b0, 1'b0},
        '{K_R, 8'd6, 8'hFF, 1'b0, 1'b0, 1'b1},
        '{K_I, 8'd0, 8'hFF, 1'b0, 1'b0, 1'b0},
        '{K_R, 8'd5, 8'hFF, 1'b1, 1'b0, 1'b0},
        '{K_I, 8'd0, 8'hFF, 1'b1, 1'b0, 1'b1},
        '{K_I, 8'd0, 8'hFF, 1'b1, 1'b0, 1'b0},
        '{K_R, 8'd6, 8'hFF, 1'b1, 1'b1, 1'b0},
        '{K_R, 8'd5, 8'hFF, 1'b1, 1'b1, 1'b0},
        '{K_R, 8'd6, 8'hFF, 1'b1, 1'b0, 1'b1},
        '{K_W, 8'd6, 8'h0F, 1'b1, 1'b0, 1'b0},
        '{K_R, 8'd6, 8'hFF, 1'b0, 1'b0, 1'b0},
        '{K_R, 8'd7, 8'hFF, 1'b0, 1'b0, 1'b1},
        '{K_B, 8'd7, 8'hFF, 1'b0, 1'b0, 1'b1},
        '{K_I, 8'd0, 8'hFF, 1'b0, 1'b0, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cyc_act = 1'b0;
    logic [7:0]  addr = '0;
    logic [71:0] wdata = '0;
    logic        gw_n = 1'b1, bw_n = 1'b1;
    logic [7:0]  ben_n = '1;
    logic        dcd_mode = 1'b0, oe_n = 1'b0, sleep = 1'b0;
    logic        adv, dq_oe;
    logic [71:0] rdata;

    int total = 0, bad = 0;
    bit done = 0;
    logic [71:0] shadow [256];
    logic [71:0] pend = '0, exp_rd = '0;

    pipe_burst_ram u0 (
        .clk(clk), .rst_n(rst_n), .cyc_act(cyc_act), .addr(addr), .wdata(wdata),
        .gw_n(gw_n), .bw_n(bw_n), .ben_n(ben_n), .dcd_mode(dcd_mode), .oe_n(oe_n),
        .sleep(sleep), .adv(adv), .rdata(rdata), .dq_oe(dq_oe)
    );

    always #(PERIOD/2) clk = ~clk;

    function automatic logic [71:0] pat(input logic [7:0] a);
        logic [71:0] v;
        for (int i = 0; i < 8; i++) v[9*i +: 9] = {a[0] ^ i[0], a ^ 8'(i * 29)};
        return v;
    endfunction

    task automatic chk(input string tag, input logic [71:0] act, input logic [71:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One clock: apply at negedge, check adv, step past the edge, update model.
    task automatic run(input logic [1:0] kind, input logic [7:0] a, input logic [7:0] benn,
                       input logic [71:0] d, input logic ok);
        logic is_wr, exp_adv;
        @(negedge clk);
        cyc_act = (kind != K_I);
        gw_n    = (kind != K_W);
        bw_n    = !(kind == K_W || kind == K_B);
        ben_n   = benn;
        addr    = a;
        wdata   = d;
        is_wr   = (kind == K_W) || (kind == K_B && benn != 8'hFF);
        exp_adv = ok && (kind != K_I);
        #1 chk("R8 adv", {71'd0, adv}, {71'd0, exp_adv});
        @(posedge clk);
        #(PERIOD/4);
        exp_rd = pend;
        if (exp_adv) begin
            if (is_wr) begin
                for (int i = 0; i < 8; i++)
                    if (kind == K_W || !benn[i]) shadow[a][9*i +: 9] = d[9*i +: 9];
            end else begin
                pend = shadow[a];
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R11 reset dq_oe", {71'd0, dq_oe}, 72'd0);
        chk("R11 reset rdata", rdata, 72'd0);
        rst_n = 1'b1;

        // Preload every word with a global write.
        for (int a = 0; a < 256; a++) run(K_W, 8'(a), 8'hFF, pat(8'(a)), 1'b1);

        // Table walk: R1..R6 under mixed modes and output enable.
        for (int i = 0; i < NV; i++) begin
            dcd_mode = VECS[i].dcd;
            oe_n     = VECS[i].oen;
            run(VECS[i].kind, VECS[i].a, VECS[i].ben, ~pat(VECS[i].a) ^ 72'(i * 7 + 1), 1'b1);
            chk($sformatf("R2/R3/R6 dq_oe vec %0d", i), {71'd0, dq_oe}, {71'd0, VECS[i].exp_oe});
            if (VECS[i].exp_oe)
                chk($sformatf("R1/R4/R5 rdata vec %0d", i), rdata, exp_rd);
        end

        // R7: asynchronous output enable inside one cycle.
        dcd_mode = 1'b0; oe_n = 1'b0;
        run(K_R, 8'd5, 8'hFF, '0, 1'b1);
        run(K_R, 8'd6, 8'hFF, '0, 1'b1);
        chk("R7 driving", {71'd0, dq_oe}, 72'd1);
        chk("R1 rdata", rdata, exp_rd);
        oe_n = 1'b1;
        #1 chk("R7 oe high", {71'd0, dq_oe}, 72'd0);
        oe_n = 1'b0;
        #1 chk("R7 oe low", {71'd0, dq_oe}, 72'd1);
        run(K_I, 8'd0, 8'hFF, '0, 1'b1);

        // R9: sleep entry while reads stream.
        run(K_R, 8'd3, 8'hFF, '0, 1'b1);
        sleep = 1'b1;
        run(K_R, 8'd4, 8'hFF, '0, 1'b1);
        chk("R9 still awake", {71'd0, dq_oe}, 72'd1);
        chk("R9 still awake rdata", rdata, exp_rd);
        run(K_R, 8'd5, 8'hFF, '0, 1'b1);
        chk("R9 asleep quiet", {71'd0, dq_oe}, 72'd0);
        run(K_W, 8'd9, 8'h00, 72'hABC, 1'b0);
        chk("R9 asleep quiet 2", {71'd0, dq_oe}, 72'd0);
        run(K_R, 8'd9, 8'hFF, '0, 1'b0);
        chk("R9 asleep quiet 3", {71'd0, dq_oe}, 72'd0);
        sleep = 1'b0;
        run(K_I, 8'd0, 8'hFF, '0, 1'b1);
        run(K_I, 8'd0, 8'hFF, '0, 1'b1);

        // R10: recovery window.
        run(K_R, 8'd9, 8'hFF, '0, 1'b1);
        for (int i = 0; i < 3; i++) run(K_W, 8'd11, 8'h00, 72'h5A5A, 1'b0);
        run(K_W, 8'd10, 8'h00, 72'h1234_5678_9ABC, 1'b1);
        run(K_R, 8'd9, 8'hFF, '0, 1'b1);
        run(K_R, 8'd11, 8'hFF, '0, 1'b1);
        chk("R9 retained word", rdata, pat(8'd9));
        run(K_R, 8'd10, 8'hFF, '0, 1'b1);
        chk("R10 blocked write", rdata, pat(8'd11));
        run(K_R, 8'd0, 8'hFF, '0, 1'b1);
        chk("R10 accepted write", rdata, 72'h1234_5678_9ABC);
        run(K_I, 8'd0, 8'hFF, '0, 1'b1);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule